// File: doc/BRIEF.md
# ADC Result Conditioning Queue

This block sits behind an analog-to-digital converter and conditions every conversion result before software or a DMA engine collects it. A 12-bit result arrives with a one-cycle strobe. The block can subtract a programmed offset from it, clamping at zero, and can left-justify it into a 16-bit word. The result is written to a holding register that software reads. The conditioned value is also queued in an eight-entry first-in first-out buffer.

The holding register keeps two flags. The valid flag shows that it holds a result that has not been collected. The overrun flag shows that a result was lost, either because it overwrote an unread value or because the queue had no room. When the queue fill level reaches a selectable threshold, the block raises a request. One mode bit routes that request to either an interrupt line or a DMA line. A bus front end turns register reads into the `hold_rd` and `q_pop` strobes.

Top module: `adc_result_fifo`

## Requirements
- R1: `hold_plain` carries the raw result with no offset applied: `{4'b0, raw}` when `just_en`=0, and `{raw, 4'b0}` when `just_en`=1. It updates on the clock edge that samples `res_stb`.
- R2: When `ofs_en`=1, the conditioned value is `raw - ofs_val`, clamped to 0 when `ofs_val` > `raw`. When `ofs_en`=0, the conditioned value is the raw result.
- R3: The offset is subtracted before justification. `hold_cond` and the queued value equal the clamped difference placed in bits [15:4] when `just_en`=1, and in bits [11:0] when `just_en`=0.
- R4: A result strobe sets `hold_valid`. A `hold_rd` strobe with no result in the same cycle clears it. A result and a read in the same cycle leave it set.
- R5: A result arriving while `hold_valid`=1 and `hold_rd`=0 sets `hold_ovr`. `hold_rd` clears `hold_ovr` unless a lost result sets it again in that same cycle.
- R6: The queue holds up to 8 entries and returns them oldest first. `q_data` shows the popped entry one cycle after the `q_pop` strobe. `q_level` gives the entry count.
- R7: A pop while the queue is empty changes neither `q_data` nor `q_level`.
- R8: A result arriving while the queue holds 8 entries and no pop occurs is dropped. The stored entries are kept and `hold_ovr` is set, even when `hold_rd` is asserted in the same cycle.
- R9: The threshold is reached when `q_level` >= 4 if `thr_full`=0, and when `q_level` = 8 if `thr_full`=1. The request output is registered and reflects the fill level after the same edge.
- R10: With `dma_mode`=1 the request appears on `dma_req` and `irq_req` stays 0. With `dma_mode`=0 the request appears on `irq_req` and `dma_req` stays 0.
- R11: Synchronous reset clears every output to 0 and empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_stb | input | 1 | One-cycle strobe: a new conversion result is present |
| res_raw | input | 12 | Raw conversion result |
| ofs_en | input | 1 | Enable offset subtraction |
| ofs_val | input | 12 | Offset to subtract |
| just_en | input | 1 | Enable 4-bit left justification |
| thr_full | input | 1 | Threshold select: 0 = half (4), 1 = full (8) |
| dma_mode | input | 1 | 1 routes the request to DMA, 0 to interrupt |
| hold_rd | input | 1 | Strobe: software collected the holding register |
| q_pop | input | 1 | Strobe: remove the oldest queue entry |
| hold_plain | output | 16 | Latest result, justified per `just_en`, without offset |
| hold_cond | output | 16 | Latest result after offset and justification |
| hold_valid | output | 1 | Holding register has an uncollected result |
| hold_ovr | output | 1 | A result was lost |
| q_data | output | 16 | Most recently popped queue entry |
| q_level | output | 4 | Number of queued entries |
| irq_req | output | 1 | Threshold request, interrupt route |
| dma_req | output | 1 | Threshold request, DMA route |

## Verification
On every cycle, the assertions check the flag rules for the holding register: valid after a result, overrun after an uncollected overwrite or a drop into a full queue. They also check that the two request lines are never high together, that a full queue raises the selected request, that the fill level never exceeds eight, that an empty pop leaves state alone, and that justified values end in four zero bits. Only the bench's scenarios can show the arithmetic: clamping at zero, the order of subtraction and shift, and the exact order in which queued values come back out.

// File: rtl/adc_pp_pkg.sv
package adc_pp_pkg;

  typedef enum logic {
    THR_HALF = 1'b0,
    THR_FULL = 1'b1
  } thr_sel_e;

  typedef enum logic {
    ROUTE_IRQ = 1'b0,
    ROUTE_DMA = 1'b1
  } req_route_e;

endpackage

// File: rtl/adc_pp_shape.sv
module adc_pp_shape #(
  parameter int RAW_W  = 12,
  parameter int JUST_W = 4,
  localparam int OUT_W = RAW_W + JUST_W
) (
  input  logic [RAW_W-1:0] raw,
  input  logic [RAW_W-1:0] ofs,
  input  logic             ofs_en,
  input  logic             just_en,
  output logic [OUT_W-1:0] plain,
  output logic [OUT_W-1:0] cond
);

  logic [RAW_W-1:0] clamped;
  logic [RAW_W-1:0] base;

  // offset first, clamp at zero, then justify
  always_comb begin
    clamped = (raw >= ofs) ? (raw - ofs) : '0;
    base    = ofs_en ? clamped : raw;
  end

  always_comb begin
    if (just_en) begin
      plain = {raw,  {JUST_W{1'b0}}};
      cond  = {base, {JUST_W{1'b0}}};
    end else begin
      plain = {{JUST_W{1'b0}}, raw};
      cond  = {{JUST_W{1'b0}}, base};
    end
  end

endmodule

// File: rtl/adc_pp_hold.sv
module adc_pp_hold #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [OUT_W-1:0] plain_in,
  input  logic [OUT_W-1:0] cond_in,
  input  logic             rd,
  input  logic             lost,
  output logic [OUT_W-1:0] plain_q,
  output logic [OUT_W-1:0] cond_q,
  output logic             valid_q,
  output logic             ovr_q
);

  logic ovr_set;

  always_comb ovr_set = (wr && valid_q && !rd) || lost;

  always_ff @(posedge clk) begin
    if (rst) begin
      plain_q <= '0;
      cond_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (wr) begin
        plain_q <= plain_in;
        cond_q  <= cond_in;
      end
      if (wr)
        valid_q <= 1'b1;
      else if (rd)
        valid_q <= 1'b0;
      if (ovr_set)
        ovr_q <= 1'b1;
      else if (rd)
        ovr_q <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_pp_fifo.sv
module adc_pp_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CNT_W-1:0] level_q,
  output logic [CNT_W-1:0] level_nx,
  output logic             dropped
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             is_full, is_empty, do_pop, do_push;

  always_comb begin
    is_full  = (level_q == CNT_W'(DEPTH));
    is_empty = (level_q == '0);
    do_pop   = pop && !is_empty;
    do_push  = push && (!is_full || do_pop);
    dropped  = push && is_full && !do_pop;
    level_nx = level_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push)
      mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)
      dout <= '0;
    else if (do_pop)
      dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      level_q <= level_nx;
    end
  end

endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
  import adc_pp_pkg::*;
#(
  parameter int RAW_W  = 12,
  parameter int JUST_W = 4,
  parameter int DEPTH  = 8,
  localparam int OUT_W = RAW_W + JUST_W,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             res_stb,
  input  logic [RAW_W-1:0] res_raw,
  input  logic             ofs_en,
  input  logic [RAW_W-1:0] ofs_val,
  input  logic             just_en,
  input  logic             thr_full,
  input  logic             dma_mode,
  input  logic             hold_rd,
  input  logic             q_pop,
  output logic [OUT_W-1:0] hold_plain,
  output logic [OUT_W-1:0] hold_cond,
  output logic             hold_valid,
  output logic             hold_ovr,
  output logic [OUT_W-1:0] q_data,
  output logic [CNT_W-1:0] q_level,
  output logic             irq_req,
  output logic             dma_req
);

  localparam int HALF = DEPTH / 2;

  logic [OUT_W-1:0] plain_w, cond_w;
  logic [CNT_W-1:0] level_nx;
  logic             dropped, hit;
  thr_sel_e         thr_sel;
  req_route_e       route;

  adc_pp_shape #(.RAW_W(RAW_W), .JUST_W(JUST_W)) u_shape (
    .raw(res_raw), .ofs(ofs_val), .ofs_en(ofs_en), .just_en(just_en),
    .plain(plain_w), .cond(cond_w)
  );

  adc_pp_fifo #(.WIDTH(OUT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(res_stb), .din(cond_w), .pop(q_pop),
    .dout(q_data), .level_q(q_level), .level_nx(level_nx), .dropped(dropped)
  );

  adc_pp_hold #(.OUT_W(OUT_W)) u_hold (
    .clk(clk), .rst(rst), .wr(res_stb), .plain_in(plain_w), .cond_in(cond_w),
    .rd(hold_rd), .lost(dropped), .plain_q(hold_plain), .cond_q(hold_cond),
    .valid_q(hold_valid), .ovr_q(hold_ovr)
  );

  always_comb begin
    thr_sel = thr_sel_e'(thr_full);
    route   = req_route_e'(dma_mode);
    hit     = (thr_sel == THR_FULL) ? (level_nx == CNT_W'(DEPTH))
                                    : (level_nx >= CNT_W'(HALF));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      irq_req <= hit && (route == ROUTE_IRQ);
      dma_req <= hit && (route == ROUTE_DMA);
    end
  end

endmodule

// File: rtl/adc_result_fifo_checker.sv
module adc_result_fifo_checker #(
  parameter int OUT_W = 16,
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             res_stb,
  input logic             just_en,
  input logic             thr_full,
  input logic             dma_mode,
  input logic             hold_rd,
  input logic             q_pop,
  input logic [OUT_W-1:0] hold_plain,
  input logic [OUT_W-1:0] q_data,
  input logic             hold_valid,
  input logic             hold_ovr,
  input logic [CNT_W-1:0] q_level,
  input logic             irq_req,
  input logic             dma_req
);

  a_r1_justified_low_zero: assert property (@(posedge clk) disable iff (rst)
    (res_stb && just_en) |=> (hold_plain[3:0] == 4'h0));

  a_r4_valid_after_result: assert property (@(posedge clk) disable iff (rst)
    res_stb |=> hold_valid);

  a_r5_ovr_on_overwrite: assert property (@(posedge clk) disable iff (rst)
    (res_stb && hold_valid && !hold_rd) |=> hold_ovr);

  a_r8_ovr_on_drop: assert property (@(posedge clk) disable iff (rst)
    (res_stb && q_level == CNT_W'(DEPTH) && !q_pop) |=> (hold_ovr && q_level == CNT_W'(DEPTH)));

  a_r6_level_bound: assert property (@(posedge clk) disable iff (rst)
    q_level <= CNT_W'(DEPTH));

  a_r7_empty_pop_quiet: assert property (@(posedge clk) disable iff (rst)
    (q_pop && q_level == '0 && !res_stb) |=> ($stable(q_data) && q_level == '0));

  a_r10_single_route: assert property (@(posedge clk) disable iff (rst)
    !(irq_req && dma_req));

  a_r9_full_raises_req: assert property (@(posedge clk) disable iff (rst)
    (q_level == CNT_W'(DEPTH) && $past(thr_full) && $past(dma_mode)) |-> dma_req);

endmodule

bind adc_result_fifo adc_result_fifo_checker #(
  .OUT_W(OUT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .res_stb(res_stb), .just_en(just_en),
  .thr_full(thr_full), .dma_mode(dma_mode), .hold_rd(hold_rd), .q_pop(q_pop),
  .hold_plain(hold_plain), .q_data(q_data), .hold_valid(hold_valid),
  .hold_ovr(hold_ovr), .q_level(q_level), .irq_req(irq_req), .dma_req(dma_req)
);

// File: tb/adc_result_fifo_bench.sv
module adc_result_fifo_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_stb = 1'b0;
  logic [11:0] res_raw = '0;
  logic        ofs_en = 1'b0;
  logic [11:0] ofs_val = '0;
  logic        just_en = 1'b0;
  logic        thr_full = 1'b0;
  logic        dma_mode = 1'b0;
  logic        hold_rd = 1'b0;
  logic        q_pop = 1'b0;
  logic [15:0] hold_plain, hold_cond, q_data;
  logic        hold_valid, hold_ovr, irq_req, dma_req;
  logic [3:0]  q_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_result_fifo u_adc_result_fifo (
    .clk(clk), .rst(rst), .res_stb(res_stb), .res_raw(res_raw),
    .ofs_en(ofs_en), .ofs_val(ofs_val), .just_en(just_en),
    .thr_full(thr_full), .dma_mode(dma_mode), .hold_rd(hold_rd), .q_pop(q_pop),
    .hold_plain(hold_plain), .hold_cond(hold_cond), .hold_valid(hold_valid),
    .hold_ovr(hold_ovr), .q_data(q_data), .q_level(q_level),
    .irq_req(irq_req), .dma_req(dma_req)
  );

  // {raw, offset, ofs_en, just_en, expected plain, expected conditioned}
  localparam logic [57:0] VEC [6] = '{
    {12'h123, 12'h100, 1'b0, 1'b0, 16'h0123, 16'h0123},
    {12'h123, 12'h100, 1'b1, 1'b0, 16'h0123, 16'h0023},
    {12'h050, 12'h100, 1'b1, 1'b0, 16'h0050, 16'h0000},
    {12'hABC, 12'h00C, 1'b1, 1'b1, 16'hABC0, 16'hAB00},
    {12'hFFF, 12'h000, 1'b0, 1'b1, 16'hFFF0, 16'hFFF0},
    {12'h100, 12'h100, 1'b1, 1'b1, 16'h1000, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one result strobe, optional collect strobe in the same cycle
  task automatic put(input logic [11:0] v, input logic rd);
    @(negedge clk);
    res_raw = v; res_stb = 1'b1; hold_rd = rd;
    @(negedge clk);
    res_stb = 1'b0; hold_rd = 1'b0;
  endtask

  task automatic collect();
    @(negedge clk); hold_rd = 1'b1;
    @(negedge clk); hold_rd = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); q_pop = 1'b1;
    @(negedge clk); q_pop = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 plain", hold_plain, 0);
    chk("R11 cond", hold_cond, 0);
    chk("R11 flags", {hold_valid, hold_ovr, irq_req, dma_req}, 0);
    chk("R11 level", q_level, 0);
    chk("R11 qdata", q_data, 0);
    rst = 1'b0;

    // R1 R2 R3: table walk
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ofs_val = VEC[i][45:34]; ofs_en = VEC[i][33]; just_en = VEC[i][32];
      put(VEC[i][57:46], 1'b1);
      chk("R1 plain", hold_plain, VEC[i][31:16]);
      chk("R2/R3 cond", hold_cond, VEC[i][15:0]);
    end
    chk("R6 level after table", q_level, 6);
    for (int i = 0; i < 6; i++) begin
      take();
      chk("R3 queued cond", q_data, VEC[i][15:0]);
    end

    // R4 R5: holding flags
    do_reset();
    ofs_en = 1'b0; just_en = 1'b0;
    put(12'h011, 1'b0);
    chk("R4 valid set", hold_valid, 1);
    chk("R5 no ovr yet", hold_ovr, 0);
    put(12'h022, 1'b1);
    chk("R4 valid kept on wr+rd", hold_valid, 1);
    chk("R5 no ovr on wr+rd", hold_ovr, 0);
    put(12'h033, 1'b0);
    chk("R5 ovr set", hold_ovr, 1);
    collect();
    chk("R4 valid cleared", hold_valid, 0);
    chk("R5 ovr cleared", hold_ovr, 0);

    // R9 R10: thresholds and routing (queue holds 3 now)
    thr_full = 1'b0; dma_mode = 1'b0;
    chk("R9 below half", irq_req, 0);
    put(12'h044, 1'b1);
    chk("R9 half irq", irq_req, 1);
    chk("R10 irq route dma low", dma_req, 0);
    @(negedge clk); dma_mode = 1'b1;
    @(negedge clk);
    chk("R10 dma route", dma_req, 1);
    chk("R10 dma route irq low", irq_req, 0);
    @(negedge clk); thr_full = 1'b1;
    @(negedge clk);
    chk("R9 full sel at 4", dma_req, 0);
    for (int i = 5; i <= 8; i++) put(12'(i * 17), 1'b1);
    chk("R9 full reached", dma_req, 1);
    chk("R6 level 8", q_level, 8);

    // R8: drop into full queue despite same-cycle collect
    put(12'h7FF, 1'b1);
    chk("R8 ovr on drop", hold_ovr, 1);
    chk("R8 level kept", q_level, 8);
    chk("R1 hold still written", hold_plain, 16'h07FF);

    // R6: drain in order
    take(); chk("R6 order 1", q_data, 16'h0011);
    take(); chk("R6 order 2", q_data, 16'h0022);
    take(); chk("R6 order 3", q_data, 16'h0033);
    take(); chk("R6 order 4", q_data, 16'h0044);
    for (int i = 5; i <= 8; i++) begin
      take(); chk("R6 order tail", q_data, 32'(12'(i * 17)));
    end
    chk("R6 empty", q_level, 0);
    chk("R9 req gone", {irq_req, dma_req}, 0);

    // R7: pop on empty
    take();
    chk("R7 qdata unchanged", q_data, 32'(12'(8 * 17)));
    chk("R7 level unchanged", q_level, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule